// File: doc/BRIEF.md
# Reset Supervisor with Activity Watchdog

This block produces the system reset for a board-level controller. Three things can cause a reset. The first is a digital supply-good flag from an outside voltage comparator. The second is a pair of shared reset pins, which outside logic may also force. The third is a watchdog that expects to see edges on a serial data line. Each cause is held for as long as it lasts. After it clears, reset is stretched by a fixed number of clock cycles and then released. The two reset pins are open-drain: the block only supplies a drive enable for each, and it reads each pin's level back through a synchronizer.

The block must tell its own drive apart from an outside one. A pin counts as externally forced only when it shows the asserted level while the block has not driven it, either now or during the last synchronizer-depth-plus-one cycles. This keeps the block from holding itself in reset. If outside logic keeps forcing a pin for longer than one stretch, the block's drive drops for a short while and then restarts. The pin stays asserted throughout, because the outside force is still holding it.

All timeouts are given in clock cycles. A parameter leaves the watchdog out entirely.

Top module: `reset_supervisor`

## Requirements
- R1: While the synchronous reset input is high, and afterwards for as long as the supply flag stays low, both drive enables are 1 (1 means the pin is driven to its asserted level).
- R2: When the supply flag goes high and stays high, both enables fall exactly SYNC_STAGES + GLITCH_CYCLES + STRETCH_CYCLES clock edges after the first edge that samples it high.
- R3: A high pulse on the supply flag lasting fewer than GLITCH_CYCLES cycles leaves reset asserted.
- R4: When the supply flag falls, both enables are 1 exactly SYNC_STAGES + 2 edges after the first edge that samples it low, with no stretch delay.
- R5: A level of 1 forced onto the active-high pin while the block is released turns the enables on SYNC_STAGES + 1 edges later. After the force is removed, the enables fall within STRETCH_CYCLES + SYNC_STAGES + 1 edges.
- R6: A level of 0 forced onto the active-low pin has the same effect. While that force lasts longer than one stretch, the block's drive is off for exactly SYNC_STAGES + 2 consecutive cycles before it restarts, and it releases after the force is removed.
- R7: After a release, if no edge is seen on the data line, the enables turn on exactly WDT_CYCLES + 1 edges after the release edge and stay on for STRETCH_CYCLES cycles.
- R8: Rising and falling edges on the data line, arriving less than WDT_CYCLES cycles apart, keep reset released.
- R9: The watchdog does not count while reset is asserted. Timing for R7 therefore always starts from zero at the release edge, whatever the data line did during reset.
- R10: With WDT_EN = 0, a quiet data line never causes a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok_i | input | 1 | Supply-above-threshold flag from an outside comparator (asynchronous) |
| sda_i | input | 1 | Serial data line watched for activity (asynchronous) |
| rst_hi_pin_i | input | 1 | Sensed level of the active-high reset pin |
| rst_lo_pin_n_i | input | 1 | Sensed level of the active-low reset pin |
| rst_hi_drv_o | output | 1 | Drive enable that pulls the active-high pin to 1 |
| rst_lo_drv_o | output | 1 | Drive enable that pulls the active-low pin to 0 |

## Verification
The hardest situation to reach is an outside force that lasts longer than a full stretch. In that case the block's own drive drops, the readback shows the pin still asserted once the masking window closes, and the drive restarts. The bench models each pin as the OR of the block's enable and a bench-controlled force, and holds the active-low force for three stretch lengths so that this gap appears and its width can be measured. The watchdog's held-cleared behaviour is exercised by stopping data-line activity before an external reset. Expiry timing is then measured from the release edge.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef struct packed {
    logic supply_low;
    logic ext_force;
    logic wdt_expired;
  } cause_t;

  function automatic logic cause_active(cause_t c);
    return c.supply_low | c.ext_force | c.wdt_expired;
  endfunction
endpackage

// File: rtl/rs_sync.sv
module rs_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= {STAGES{RST_VAL}};
    else     chain <= {chain[STAGES-2:0], d_i};
  end

  assign q_o = chain[STAGES-1];
endmodule

// File: rtl/rs_supply_filter.sv
module rs_supply_filter #(
  parameter int unsigned GLITCH_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic level_i,
  output logic good_o
);
  localparam int unsigned CW = (GLITCH_CYCLES > 1) ? $clog2(GLITCH_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(GLITCH_CYCLES - 1);

  logic [CW-1:0] run_len;

  // Low is believed at once; high must last GLITCH_CYCLES samples in a row.
  always_ff @(posedge clk) begin
    if (rst || !level_i) begin
      good_o  <= 1'b0;
      run_len <= '0;
    end else if (!good_o) begin
      if (run_len == LAST) good_o <= 1'b1;
      else                 run_len <= run_len + CW'(1);
    end
  end
endmodule

// File: rtl/rs_activity_wdt.sv
module rs_activity_wdt #(
  parameter int unsigned WDT_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic hold_clear_i,
  input  logic line_i,
  output logic expire_o
);
  localparam int unsigned CW = (WDT_CYCLES > 1) ? $clog2(WDT_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(WDT_CYCLES - 1);

  logic [CW-1:0] idle_cnt;
  logic          line_prev;
  logic          toggled;

  assign toggled = line_i ^ line_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      line_prev <= 1'b1;
      idle_cnt  <= '0;
      expire_o  <= 1'b0;
    end else begin
      line_prev <= line_i;
      if (hold_clear_i || toggled) begin
        idle_cnt <= '0;
        expire_o <= 1'b0;
      end else if (idle_cnt == LAST) begin
        idle_cnt <= '0;
        expire_o <= 1'b1;
      end else begin
        idle_cnt <= idle_cnt + CW'(1);
        expire_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/reset_supervisor.sv
module reset_supervisor
  import rs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES    = 2,
  parameter int unsigned GLITCH_CYCLES  = 16,
  parameter int unsigned STRETCH_CYCLES = 25_000_000,
  parameter int unsigned WDT_CYCLES     = 200_000_000,
  parameter bit          WDT_EN         = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok_i,
  input  logic sda_i,
  input  logic rst_hi_pin_i,
  input  logic rst_lo_pin_n_i,
  output logic rst_hi_drv_o,
  output logic rst_lo_drv_o
);
  localparam int unsigned SCW = (STRETCH_CYCLES > 1) ? $clog2(STRETCH_CYCLES) : 1;
  localparam logic [SCW-1:0] STRETCH_LAST = SCW'(STRETCH_CYCLES - 1);

  logic sup_s, sda_s, hi_s, lo_n_s;
  logic sup_good, wdt_exp, ext_cause, own_drive, drv_q;
  logic [SYNC_STAGES:0] own_hist;
  logic [SCW-1:0]       stretch_cnt;
  cause_t               cause;

  rs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sup (
    .clk(clk), .rst(rst), .d_i(supply_ok_i), .q_o(sup_s));
  rs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
    .clk(clk), .rst(rst), .d_i(sda_i), .q_o(sda_s));
  rs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_hi (
    .clk(clk), .rst(rst), .d_i(rst_hi_pin_i), .q_o(hi_s));
  rs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_lo (
    .clk(clk), .rst(rst), .d_i(rst_lo_pin_n_i), .q_o(lo_n_s));

  rs_supply_filter #(.GLITCH_CYCLES(GLITCH_CYCLES)) u_filter (
    .clk(clk), .rst(rst), .level_i(sup_s), .good_o(sup_good));

  generate
    if (WDT_EN) begin : g_wdt
      rs_activity_wdt #(.WDT_CYCLES(WDT_CYCLES)) u_wdt (
        .clk(clk), .rst(rst), .hold_clear_i(drv_q),
        .line_i(sda_s), .expire_o(wdt_exp));
    end else begin : g_no_wdt
      assign wdt_exp = 1'b0;
    end
  endgenerate

  // Own drive is still visible at the synchronizer outputs for
  // SYNC_STAGES+1 cycles after release; mask the readback that long.
  always_ff @(posedge clk) begin
    if (rst) own_hist <= '0;
    else     own_hist <= {own_hist[SYNC_STAGES-1:0], drv_q};
  end

  assign own_drive = drv_q | (|own_hist);
  assign ext_cause = (hi_s | ~lo_n_s) & ~own_drive;

  always_comb begin
    cause.supply_low  = ~sup_good;
    cause.ext_force   = ext_cause;
    cause.wdt_expired = wdt_exp;
  end

  always_ff @(posedge clk) begin
    if (rst || cause_active(cause)) begin
      drv_q       <= 1'b1;
      stretch_cnt <= '0;
    end else if (drv_q) begin
      if (stretch_cnt == STRETCH_LAST) drv_q <= 1'b0;
      else                             stretch_cnt <= stretch_cnt + SCW'(1);
    end
  end

  assign rst_hi_drv_o = drv_q;
  assign rst_lo_drv_o = drv_q;
endmodule

// File: rtl/rs_checker.sv
module rs_checker (
  input logic clk,
  input logic rst,
  input logic sup_good,
  input logic ext_cause,
  input logic wdt_exp,
  input logic drive_hi,
  input logic drive_lo
);
  p_reset_drives_r1: assert property (@(posedge clk)
    rst |=> (drive_hi && drive_lo));

  p_release_needs_supply_r2: assert property (@(posedge clk) disable iff (rst)
    $fell(drive_hi) |-> $past(sup_good));

  p_supply_low_asserts_r4: assert property (@(posedge clk) disable iff (rst)
    !sup_good |=> drive_hi);

  p_ext_force_asserts_r5: assert property (@(posedge clk) disable iff (rst)
    ext_cause |=> (drive_hi && drive_lo));

  p_expiry_asserts_r7: assert property (@(posedge clk) disable iff (rst)
    wdt_exp |=> drive_hi);

  p_wdt_quiet_in_reset_r9: assert property (@(posedge clk) disable iff (rst)
    drive_hi |=> !wdt_exp);
endmodule

bind reset_supervisor rs_checker u_rs_checker (
  .clk(clk), .rst(rst), .sup_good(sup_good), .ext_cause(ext_cause),
  .wdt_exp(wdt_exp), .drive_hi(rst_hi_drv_o), .drive_lo(rst_lo_drv_o));

// File: tb/test_reset_supervisor.sv
module test_reset_supervisor;
  localparam int N = 2;
  localparam int G = 4;
  localparam int S = 40;
  localparam int W = 60;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply = 1'b0;
  logic sda = 1'b1;
  logic ext_hi = 1'b0;
  logic ext_lo = 1'b0;
  logic kick_en = 1'b0;
  logic drv_hi, drv_lo, nw_hi, nw_lo;
  logic pin_hi, pin_lo_n, nw_pin_hi, nw_pin_lo_n;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  assign pin_hi      = drv_hi | ext_hi;
  assign pin_lo_n    = ~(drv_lo | ext_lo);
  assign nw_pin_hi   = nw_hi | ext_hi;
  assign nw_pin_lo_n = ~(nw_lo | ext_lo);

  reset_supervisor #(.SYNC_STAGES(N), .GLITCH_CYCLES(G), .STRETCH_CYCLES(S),
                     .WDT_CYCLES(W), .WDT_EN(1'b1)) i_reset_supervisor (
    .clk(clk), .rst(rst), .supply_ok_i(supply), .sda_i(sda),
    .rst_hi_pin_i(pin_hi), .rst_lo_pin_n_i(pin_lo_n),
    .rst_hi_drv_o(drv_hi), .rst_lo_drv_o(drv_lo));

  reset_supervisor #(.SYNC_STAGES(N), .GLITCH_CYCLES(G), .STRETCH_CYCLES(S),
                     .WDT_CYCLES(W), .WDT_EN(1'b0)) i_reset_supervisor_nowdt (
    .clk(clk), .rst(rst), .supply_ok_i(supply), .sda_i(sda),
    .rst_hi_pin_i(nw_pin_hi), .rst_lo_pin_n_i(nw_pin_lo_n),
    .rst_hi_drv_o(nw_hi), .rst_lo_drv_o(nw_lo));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit sq[$], dq[$], hq[$], lq[$], hist[$];
  bit m_good, m_sda_prev, m_exp, m_rst, own, ext, hold, tog, n_rst, hi_in, lo_in;
  int m_gc, m_wc, m_sc;

  always @(posedge clk) begin
    if (rst) begin
      sq.delete(); dq.delete(); hq.delete(); lq.delete(); hist.delete();
      for (int i = 0; i < N; i++) begin
        sq.push_back(0); dq.push_back(1); hq.push_back(0); lq.push_back(1);
      end
      for (int i = 0; i <= N; i++) hist.push_back(0);
      m_good = 0; m_gc = 0; m_sda_prev = 1; m_wc = 0; m_exp = 0;
      m_rst = 1; m_sc = 0;
    end else begin
      hi_in = m_rst | ext_hi;
      lo_in = !(m_rst | ext_lo);
      tog = dq[0] != m_sda_prev;
      own = m_rst;
      foreach (hist[i]) own = own | hist[i];
      ext = (hq[0] || !lq[0]) && !own;
      hold = !m_good || ext || m_exp;
      n_rst = m_rst;
      if (hold) begin n_rst = 1; m_sc = 0; end
      else if (m_rst) begin
        if (m_sc == S - 1) n_rst = 0; else m_sc++;
      end
      if (m_rst || tog) begin m_wc = 0; m_exp = 0; end
      else if (m_wc == W - 1) begin m_wc = 0; m_exp = 1; end
      else begin m_wc++; m_exp = 0; end
      if (!sq[0]) begin m_good = 0; m_gc = 0; end
      else if (!m_good) begin
        if (m_gc == G - 1) m_good = 1; else m_gc++;
      end
      m_sda_prev = dq[0];
      hist.pop_front(); hist.push_back(m_rst);
      void'(sq.pop_front()); sq.push_back(supply);
      void'(dq.pop_front()); dq.push_back(sda);
      void'(hq.pop_front()); hq.push_back(hi_in);
      void'(lq.pop_front()); lq.push_back(lo_in);
      m_rst = n_rst;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(drv_hi == m_rst && drv_lo == m_rst, "model compare",
            {drv_hi, drv_lo}, {m_rst, m_rst});
    end
  end

  // ---------------- data-line activity ----------------
  initial begin
    int kc = 0;
    forever begin
      @(negedge clk);
      if (kick_en) begin
        kc++;
        if (kc >= 20) begin sda = ~sda; kc = 0; end
      end
    end
  end

  task automatic edges_until(input logic want, output int n);
    n = 0;
    do begin
      @(posedge clk); @(negedge clk); n++;
    end while (drv_hi != want && n < 5000);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n, run, max_run;
    bit seen;
    repeat (4) @(negedge clk);
    check(drv_hi && drv_lo, "R1 during reset", {drv_hi, drv_lo}, 3);
    rst = 1'b0;
    repeat (50) @(negedge clk);
    check(drv_hi && drv_lo && nw_hi, "R1 supply low", {drv_hi, drv_lo}, 3);

    // R3: short supply pulse
    supply = 1'b1;
    repeat (G - 1) @(negedge clk);
    supply = 1'b0;
    repeat (60) @(negedge clk);
    check(drv_hi, "R3 glitch ignored", drv_hi, 1);

    // R2: power-up stretch
    kick_en = 1'b1;
    supply = 1'b1;
    edges_until(1'b0, n);
    check(n == N + G + S, "R2 power-up release", n, N + G + S);

    // R8: activity keeps reset released
    seen = 0;
    repeat (5 * W) begin
      @(negedge clk);
      if (drv_hi) seen = 1;
    end
    check(!seen, "R8 kicks keep released", seen, 0);

    // R5: forced active-high pin
    kick_en = 1'b0;
    ext_hi = 1'b1;
    edges_until(1'b1, n);
    check(n == N + 1, "R5 forced high asserts", n, N + 1);
    repeat (10) @(negedge clk);
    ext_hi = 1'b0;
    edges_until(1'b0, n);
    check(n <= S + N + 1, "R5 release after force", n, S + N + 1);

    // R7 / R9: quiet line, count starts from zero at release
    edges_until(1'b1, n);
    check(n == W + 1, "R7 R9 expiry from release", n, W + 1);
    edges_until(1'b0, n);
    check(n == S, "R7 expiry stretch length", n, S);
    kick_en = 1'b1;

    // R6: long forced active-low pin with self-drive gap
    repeat (5) @(negedge clk);
    ext_lo = 1'b1;
    edges_until(1'b1, n);
    check(n == N + 1, "R6 forced low asserts", n, N + 1);
    run = 0; max_run = 0;
    repeat (3 * S) begin
      @(negedge clk);
      if (!drv_lo) begin run++; if (run > max_run) max_run = run; end
      else run = 0;
    end
    check(max_run == N + 2, "R6 drive gap width", max_run, N + 2);
    ext_lo = 1'b0;
    edges_until(1'b0, n);
    check(n <= S + N + 1, "R6 release after force", n, S + N + 1);

    // R4: power-down without stretch
    repeat (10) @(negedge clk);
    supply = 1'b0;
    edges_until(1'b1, n);
    check(n == N + 2, "R4 power-down assert", n, N + 2);
    repeat (20) @(negedge clk);
    supply = 1'b1;
    edges_until(1'b0, n);
    check(n == N + G + S, "R2 second power-up", n, N + G + S);

    // R10: variant without watchdog
    check(!nw_hi && !nw_lo, "R10 variant released", {nw_hi, nw_lo}, 0);
    kick_en = 1'b0;
    seen = 0;
    repeat (3 * W) begin
      @(negedge clk);
      if (nw_hi || nw_lo) seen = 1;
    end
    check(!seen, "R10 quiet line ignored", seen, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule